// File: doc/BRIEF.md
# Steerable Processor Watchdog

This block supervises a processor through one 8-bit control register. Software loads a 5-bit multiplier and a 2-bit resolution code, and the block counts strobes from a 16 Hz timebase until the programmed timeout is reached. Any read or write of the register restarts the count, so a healthy program keeps the watchdog quiet by touching the register regularly. A multiplier of zero disables the watchdog. Power-on is modelled by a synchronous reset, which clears the register and so leaves the watchdog disabled.

The top bit of the register steers the timeout. With the bit clear, a timeout sets a sticky flag and pulls the shared active-low interrupt / frequency-test pin low. The flag stays set until it is read or the register is accessed. With the bit set, a timeout drives a fixed-length active-low reset pulse. It also clears the register and strobes a request that clears the external frequency-test enable. While the watchdog is steered to the interrupt and is enabled, it owns the shared pin and the frequency-test wave does not reach it.

Top module: `wdog_steer`

## Requirements
- R1: After reset, `reg_rdata` is 00h, `wd_flag` is 0, `ft_clr` is 0 and `sys_rst_n` is 1. `irq_ft_n` then follows the frequency-test rule of R9.
- R2: A cycle with `reg_sel` and `reg_wr` high stores `reg_wdata`, and `reg_rdata` shows the stored value from the next cycle on. Bit 7 is the steering bit, bits 6:2 the multiplier M, and bits 1:0 the resolution code C.
- R3: The timeout occurs on the (M × 4^C)-th `tick` strobe after the last restart. C = 0, 1, 2 and 3 give 1, 4, 16 and 64 ticks per multiplier unit, so 8'b00001110 times out after 48 ticks (3 s).
- R4: A cycle with `reg_sel` high together with `reg_rd` or `reg_wr` is an access, and an access restarts the count from zero.
- R5: With M = 0, including the value 00h, no timeout ever occurs.
- R6: On a timeout with the steering bit at 0, `wd_flag` goes to 1 on the next cycle. It stays at 1 until a cycle with `flag_rd` high or a register access, after which it reads 0.
- R7: On a timeout with the steering bit at 1, `sys_rst_n` goes low on the next cycle. It returns high after PULSE_TICKS further `tick` strobes, which is 2 by default.
- R8: On a timeout with the steering bit at 1, the register is cleared to 00h and `ft_clr` is high for exactly one cycle. That cycle is the first low cycle of `sys_rst_n`.
- R9: When the steering bit is 0 and M is non-zero, `irq_ft_n` equals the inverse of `wd_flag`, and `ft_wave` has no effect on it. Otherwise `irq_ft_n` equals `ft_wave` when `ft_en` is 1, and 1 when `ft_en` is 0.
- R10: When an access and the timeout tick fall in the same cycle, the access wins. The count restarts, and neither the flag, the pulse nor `ft_clr` appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | One-cycle timebase strobe at TICK_HZ |
| reg_sel | input | 1 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| flag_rd | input | 1 | Read of the watchdog flag, clears it |
| wd_flag | output | 1 | Sticky watchdog timeout flag |
| ft_en | input | 1 | Frequency-test enable |
| ft_wave | input | 1 | Frequency-test square wave |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test enable |
| irq_ft_n | output | 1 | Resolved shared interrupt / frequency-test pin, active low |
| sys_rst_n | output | 1 | Watchdog reset pulse, active low |

## Verification
The bench builds the block with its default parameters: a 16 Hz timebase and a two-tick reset pulse. It drives `tick` as a free strobe, often on every clock, so the longest timeout of 31 × 64 ticks fits within a short run. Multipliers are kept small under random stimulus, which lets all four resolution codes, both steering choices and collisions between an access and a timeout tick occur many times. The two-tick pulse makes the end of the reset pulse and the restart of the count after an access observable within a few ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int MULT_W    = 5;
    localparam int RES_W     = 2;
    localparam int CTRL_W    = 1 + MULT_W + RES_W;
    localparam int SHIFT_MAX = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W     = MULT_W + SHIFT_MAX;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_ctrl_t;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_FREQ = 2'd1,
        SRC_WDOG = 2'd2
    } pin_src_t;

    function automatic logic [CNT_W-1:0] timeout_ticks(input wd_ctrl_t c);
        logic [CNT_W-1:0] m;
        m = CNT_W'(c.mult);
        return m << {c.res, 1'b0};
    endfunction

    function automatic logic is_enabled(input wd_ctrl_t c);
        return |c.mult;
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              auto_clr,
    output wd_ctrl_t          ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wd_ctrl_t'(wdata);
        end else if (auto_clr) begin
            ctrl <= '0;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     restart,
    input  wd_ctrl_t ctrl,
    output logic     expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             en;

    always_comb begin
        limit  = timeout_ticks(ctrl);
        en     = is_enabled(ctrl);
        expire = en && tick && !restart && (cnt == limit - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || expire) begin
            cnt <= '0;
        end else if (en && tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdog_output.sv
module wdog_output
    import wdog_pkg::*;
#(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic expire,
    input  logic steer,
    input  logic owns_pin,
    input  logic access,
    input  logic flag_rd,
    input  logic ft_en,
    input  logic ft_wave,
    output logic wd_flag,
    output logic ft_clr,
    output logic irq_ft_n,
    output logic sys_rst_n
);
    localparam int PCNT_W = $clog2(PULSE_TICKS + 1);

    logic [PCNT_W-1:0] pcnt;
    pin_src_t          src;

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_flag <= 1'b0;
            ft_clr  <= 1'b0;
            pcnt    <= '0;
        end else begin
            ft_clr <= expire && steer;
            if (expire && !steer) begin
                wd_flag <= 1'b1;
            end else if (access || flag_rd) begin
                wd_flag <= 1'b0;
            end
            if (expire && steer) begin
                pcnt <= PCNT_W'(PULSE_TICKS);
            end else if (pcnt != '0 && tick) begin
                pcnt <= pcnt - PCNT_W'(1);
            end
        end
    end

    always_comb begin
        if (owns_pin)   src = SRC_WDOG;
        else if (ft_en) src = SRC_FREQ;
        else            src = SRC_IDLE;
        case (src)
            SRC_WDOG: irq_ft_n = !wd_flag;
            SRC_FREQ: irq_ft_n = ft_wave;
            default:  irq_ft_n = 1'b1;
        endcase
        sys_rst_n = (pcnt == '0);
    end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
    import wdog_pkg::*;
#(
    parameter int TICK_HZ      = 16,
    parameter int PULSE_TICKS  = 2,
    parameter int PULSE_MIN_MS = 40,
    parameter int PULSE_MAX_MS = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              flag_rd,
    output logic              wd_flag,
    input  logic              ft_en,
    input  logic              ft_wave,
    output logic              ft_clr,
    output logic              irq_ft_n,
    output logic              sys_rst_n
);
    localparam int PULSE_MS = (PULSE_TICKS * 1000) / TICK_HZ;

    generate
        if (PULSE_MS < PULSE_MIN_MS || PULSE_MS > PULSE_MAX_MS) begin : g_bad_pulse
            $error("reset pulse length outside the allowed window");
        end
    endgenerate

    wd_ctrl_t ctrl;
    logic     access;
    logic     expire;
    logic     owns_pin;

    assign access    = reg_sel && (reg_rd || reg_wr);
    assign owns_pin  = !ctrl.steer && is_enabled(ctrl);
    assign reg_rdata = ctrl;

    wdog_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_sel && reg_wr),
        .wdata    (reg_wdata),
        .auto_clr (expire && ctrl.steer),
        .ctrl     (ctrl)
    );

    wdog_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (access),
        .ctrl    (ctrl),
        .expire  (expire)
    );

    wdog_output #(.PULSE_TICKS(PULSE_TICKS)) u_out (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .expire    (expire),
        .steer     (ctrl.steer),
        .owns_pin  (owns_pin),
        .access    (access),
        .flag_rd   (flag_rd),
        .ft_en     (ft_en),
        .ft_wave   (ft_wave),
        .wd_flag   (wd_flag),
        .ft_clr    (ft_clr),
        .irq_ft_n  (irq_ft_n),
        .sys_rst_n (sys_rst_n)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              access,
    input logic              expire,
    input logic              flag_rd,
    input logic [CTRL_W-1:0] rdata,
    input logic              wd_flag,
    input logic              ft_en,
    input logic              ft_wave,
    input logic              ft_clr,
    input logic              irq_ft_n,
    input logic              sys_rst_n
);
    wd_ctrl_t c;
    logic     owned;
    assign c     = wd_ctrl_t'(rdata);
    assign owned = !c.steer && (c.mult != '0);

    AST_ACCESS_BEATS_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        access |-> !expire); // R10
    AST_ACCESS_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        access |=> !wd_flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wd_flag && !access && !flag_rd) |=> wd_flag); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (c.mult == '0) |-> !expire); // R5
    AST_STEER_CLEARS_REG: assert property (@(posedge clk) disable iff (rst)
        ft_clr |-> (rdata == '0 && !sys_rst_n)); // R8
    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n) |-> ft_clr); // R7
    AST_PIN_OWNED: assert property (@(posedge clk) disable iff (rst)
        owned |-> (irq_ft_n == !wd_flag)); // R9
    AST_PIN_FREE: assert property (@(posedge clk) disable iff (rst)
        (!owned && !wd_flag) |-> (irq_ft_n == (ft_en ? ft_wave : 1'b1))); // R9
endmodule

bind wdog_steer wdog_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .access    (access),
    .expire    (expire),
    .flag_rd   (flag_rd),
    .rdata     (reg_rdata),
    .wd_flag   (wd_flag),
    .ft_en     (ft_en),
    .ft_wave   (ft_wave),
    .ft_clr    (ft_clr),
    .irq_ft_n  (irq_ft_n),
    .sys_rst_n (sys_rst_n)
);

// File: tb/tb_wdog_steer.sv
module tb_wdog_steer;
    localparam int PULSE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       flag_rd = 1'b0;
    logic       wd_flag;
    logic       ft_en = 1'b0, ft_wave = 1'b0;
    logic       ft_clr, irq_ft_n, sys_rst_n;

    int  tests = 0;
    int  fails = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    wdog_steer #(.TICK_HZ(16), .PULSE_TICKS(PULSE)) dut (
        .clk(clk), .rst(rst), .tick(tick), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flag_rd(flag_rd), .wd_flag(wd_flag), .ft_en(ft_en), .ft_wave(ft_wave),
        .ft_clr(ft_clr), .irq_ft_n(irq_ft_n), .sys_rst_n(sys_rst_n)
    );

    // Reference model built from the requirements
    logic [7:0] m_ctrl = 8'h00;
    int         m_cnt = 0;
    logic       m_flag = 1'b0;
    int         m_pcnt = 0;
    logic       m_ftclr = 1'b0;

    function automatic int lim(input logic [7:0] c);
        return int'(c[6:2]) * (1 << (2 * int'(c[1:0])));
    endfunction

    function automatic logic exp_pin(input logic [7:0] c, input logic f,
                                     input logic en, input logic w);
        if (!c[7] && c[6:2] != 5'd0) return !f;
        return en ? w : 1'b1;
    endfunction

    always @(posedge clk) begin
        logic acc, on, ex;
        if (rst) begin
            m_ctrl <= 8'h00; m_cnt <= 0; m_flag <= 1'b0; m_pcnt <= 0; m_ftclr <= 1'b0;
        end else begin
            acc = reg_sel && (reg_rd || reg_wr);
            on  = (m_ctrl[6:2] != 5'd0);
            ex  = on && tick && !acc && (m_cnt + 1 == lim(m_ctrl));
            if (acc && reg_wr)        m_ctrl <= reg_wdata;
            else if (ex && m_ctrl[7]) m_ctrl <= 8'h00;
            if (acc || ex)            m_cnt <= 0;
            else if (on && tick)      m_cnt <= m_cnt + 1;
            if (ex && !m_ctrl[7])     m_flag <= 1'b1;
            else if (acc || flag_rd)  m_flag <= 1'b0;
            if (ex && m_ctrl[7])          m_pcnt <= PULSE;
            else if (m_pcnt != 0 && tick) m_pcnt <= m_pcnt - 1;
            m_ftclr <= ex && m_ctrl[7];
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R2 rdata", reg_rdata, m_ctrl);
            check("R6 flag", {7'd0, wd_flag}, {7'd0, m_flag});
            check("R7 reset pulse", {7'd0, sys_rst_n}, {7'd0, m_pcnt == 0});
            check("R8 ft_clr", {7'd0, ft_clr}, {7'd0, m_ftclr});
            check("R9 pin", {7'd0, irq_ft_n},
                  {7'd0, exp_pin(m_ctrl, m_flag, ft_en, ft_wave)});
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; flag_rd = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] d, input logic t);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d; tick = t;
        step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
        end
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst = 1'b0;
        step();
        cmp_en = 1'b1;
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 flag", {7'd0, wd_flag}, 8'd0);
        check("R1 rst_n", {7'd0, sys_rst_n}, 8'd1);
        check("R1 pin", {7'd0, irq_ft_n}, 8'd1);
        check("R1 ft_clr", {7'd0, ft_clr}, 8'd0);

        // R3: 8'b00001110 -> 48 ticks
        write_reg(8'h0E, 1'b0);
        check("R2 stored", reg_rdata, 8'h0E);
        ticks(47);
        check("R3 before limit", {7'd0, wd_flag}, 8'd0);
        ticks(1);
        check("R3 at limit flag", {7'd0, wd_flag}, 8'd1);
        check("R6 pin low", {7'd0, irq_ft_n}, 8'd0);
        // R6 sticky, cleared by flag read
        ticks(5);
        check("R6 sticky", {7'd0, wd_flag}, 8'd1);
        flag_rd = 1'b1; step();
        check("R6 cleared by flag read", {7'd0, wd_flag}, 8'd0);
        check("R6 pin released", {7'd0, irq_ft_n}, 8'd1);
        // R4 access restarts count
        ticks(40);
        reg_sel = 1'b1; reg_rd = 1'b1; step();
        ticks(47);
        check("R4 restarted", {7'd0, wd_flag}, 8'd0);
        ticks(1);
        check("R4 full period", {7'd0, wd_flag}, 8'd1);
        // R6 cleared by write; R5 disabled
        write_reg(8'h00, 1'b0);
        check("R6 cleared by write", {7'd0, wd_flag}, 8'd0);
        ticks(200);
        check("R5 00h disabled", {7'd0, wd_flag}, 8'd0);
        write_reg(8'h83, 1'b0);
        ticks(200);
        check("R5 zero multiplier", {6'd0, sys_rst_n, wd_flag}, 8'd2);

        // R10 access vs timeout tick; R9 ownership
        ft_en = 1'b1; ft_wave = 1'b0;
        write_reg(8'h04, 1'b0);
        reg_sel = 1'b1; reg_rd = 1'b1; tick = 1'b1; step(); tick = 1'b0;
        check("R10 access wins", {7'd0, wd_flag}, 8'd0);
        check("R9 ft blocked", {7'd0, irq_ft_n}, 8'd1);
        ticks(1);
        check("R10 later tick expires", {7'd0, wd_flag}, 8'd1);
        write_reg(8'h00, 1'b0);
        ft_wave = 1'b0; step();
        check("R9 ft wave low", {7'd0, irq_ft_n}, 8'd0);
        ft_wave = 1'b1; step();
        check("R9 ft wave high", {7'd0, irq_ft_n}, 8'd1);
        ft_en = 1'b0; ft_wave = 1'b0; step();
        check("R9 ft disabled", {7'd0, irq_ft_n}, 8'd1);
        ft_en = 1'b1;
        write_reg(8'h84, 1'b0);
        check("R9 steered to reset, ft passes", {7'd0, irq_ft_n}, 8'd0);
        ft_en = 1'b0;

        // R7 / R8 reset pulse
        write_reg(8'h85, 1'b0);
        ticks(3);
        check("R7 before limit", {7'd0, sys_rst_n}, 8'd1);
        ticks(1);
        check("R7 pulse low", {7'd0, sys_rst_n}, 8'd0);
        check("R8 ft_clr", {7'd0, ft_clr}, 8'd1);
        check("R8 reg cleared", reg_rdata, 8'h00);
        step();
        check("R8 ft_clr one cycle", {7'd0, ft_clr}, 8'd0);
        check("R7 still low", {7'd0, sys_rst_n}, 8'd0);
        ticks(1);
        check("R7 low after one tick", {7'd0, sys_rst_n}, 8'd0);
        ticks(1);
        check("R7 released", {7'd0, sys_rst_n}, 8'd1);
        check("R5 cleared reg stays quiet", {7'd0, wd_flag}, 8'd0);

        // Constrained random phase, checked by the model every cycle
        for (int i = 0; i < 6000; i++) begin
            tick    = ($urandom % 3) != 0;
            ft_wave = $urandom % 2;
            if ($urandom % 97 == 0) ft_en = ~ft_en;
            flag_rd = ($urandom % 31 == 0);
            if ($urandom % 50 == 0) begin
                reg_sel   = ($urandom % 8) != 0;
                reg_wr    = $urandom % 2;
                reg_rd    = !reg_wr || ($urandom % 4 == 0);
                reg_wdata = {1'($urandom % 2), 5'($urandom % 4), 2'($urandom % 4)};
            end
            @(posedge clk);
            #2;
            reg_sel = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; flag_rd = 1'b0;
        end
        tick = 1'b0;
        step();
        finish_run();
    end
endmodule